// File: doc/BRIEF.md
# Bus Cycle Trace Ring Buffer

This block keeps a rolling history of the bus cycles made by an emulated 8-bit processor. Each recorded cycle stores a 16-bit address, an 8-bit data byte and three cycle-type flags: opcode fetch, read and write. The history is a circular store of 252 entries. Once it is full, each new cycle replaces the oldest one. Recording continues at full speed and in single-step execution, so the history stays in true time order no matter how the two kinds of execution are mixed.

When the processor is paused, an operator can move a cursor through the history. The cursor can step one cycle at a time toward older or newer entries. It can also jump straight to the previous or next opcode-fetch cycle. When a pause begins, the cursor is placed on a meaningful entry:

- If the pause was caused by a breakpoint, the cursor goes to the cycle that raised the breakpoint.
- If the pause was a manual stop, the cursor goes to the fetch of the last instruction.

The entry under the cursor is always shown on the view outputs.

Captures arrive on a valid/ready interface. The block never stalls an accepted cycle:

- `cap_ready` is low only while reset is held.
- A cycle is accepted on every clock edge where `cap_valid` and `cap_ready` are both high.
- An accepted cycle is dropped, rather than stored, when `inhibit` is high while `running` is high.

All other pins are plain levels. The cursor is given as an age: 0 is the newest entry and larger numbers are older entries.

Top module: `trace_ring`

## Requirements
- R1: While reset is held, `cap_ready` is 0, `view_valid` is 0 and `view_age` is 0. The history is empty.
- R2: After reset, `cap_ready` is 1. Every accepted cycle that is not dropped becomes the newest entry, holding the captured address, data, fetch, read and write values exactly.
- R3: The history holds at most 252 entries. After more than 252 records, the oldest reachable entry (age 251) is the 252nd most recent cycle.
- R4: Cycles accepted while paused, as in single-step execution, are recorded as well. They take their place in time order after the cycles recorded while running.
- R5: An accepted cycle is dropped when `inhibit` and `running` are both 1. While paused, `inhibit` has no effect.
- R6: While `running` is 1, `br_inc` and `br_dec` are ignored and the cursor does not move.
- R7: While paused, `br_dec` moves the cursor one entry older and stops at the oldest stored entry. `br_inc` moves it one entry newer and stops at age 0. When both are high in the same cycle, the cursor does not move.
- R8: While paused with `br_skip` high, `br_inc` moves the cursor to the nearest newer entry whose fetch flag is 1. `br_dec` moves it to the nearest older entry whose fetch flag is 1. If no such entry exists in that direction, the cursor does not move.
- R9: On the cycle where `running` falls with `stop_bkpt` high, the cursor goes to the newest stored entry that was captured with `cap_bkpt` high. If no such entry is stored, R10 applies instead.
- R10: On a pause that is not placed by R9, the cursor goes to the newest stored fetch entry. The same happens after each cycle recorded while paused. If no fetch entry is stored, the cursor goes to age 0.
- R11: `view_age` gives the cursor age. The view outputs show, in the same cycle, the fields of the entry at that age. `view_valid` is 1 whenever the history is not empty.
- R12: When a cycle is recorded while paused, any browse command in that same cycle is ignored in favour of the R10 placement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_valid | input | 1 | Capture cycle offered |
| cap_ready | output | 1 | Capture accepted; low only in reset |
| cap_addr | input | 16 | Captured cycle address |
| cap_data | input | 8 | Captured cycle data |
| cap_fetch | input | 1 | Cycle is an opcode fetch |
| cap_rd | input | 1 | Cycle is a read |
| cap_wr | input | 1 | Cycle is a write |
| cap_bkpt | input | 1 | Breakpoint detected on this cycle |
| inhibit | input | 1 | Suppress recording while running |
| running | input | 1 | 1 = run, 0 = pause |
| stop_bkpt | input | 1 | Pause cause: 1 = breakpoint, 0 = manual |
| br_inc | input | 1 | Browse toward newer entries |
| br_dec | input | 1 | Browse toward older entries |
| br_skip | input | 1 | Browse by opcode fetch only |
| view_addr | output | 16 | Address of the entry under the cursor |
| view_data | output | 8 | Data of the entry under the cursor |
| view_fetch | output | 1 | Fetch flag of the entry under the cursor |
| view_rd | output | 1 | Read flag of the entry under the cursor |
| view_wr | output | 1 | Write flag of the entry under the cursor |
| view_age | output | 8 | Cursor age, 0 = newest |
| view_valid | output | 1 | History holds at least one entry |

## Verification
A wrong write pointer or fill count shows up at the first pause. After the next browse step, the view fields no longer match the cycle that was expected at that age. A fill count that is off by one shows up when the cursor stops one step early or one step late against the oldest entry.

A stale fetch or breakpoint age shows up on the very cycle after a pause begins, as a wrong `view_age`. A fault in the fetch scan shows up after one skip command, as a cursor that lands on a non-fetch entry or moves when it should not.

// File: rtl/trace_pkg.sv
package trace_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic              fetch;
    logic              rd;
    logic              wr;
  } trace_ent_t;
endpackage

// File: rtl/trace_store.sv
module trace_store
  import trace_pkg::*;
#(
  parameter int DEPTH = 252
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  trace_ent_t                   wr_ent,
  input  logic [$clog2(DEPTH)-1:0]     rd_age,
  output trace_ent_t                   rd_ent,
  output logic [$clog2(DEPTH+1)-1:0]   fill,
  output logic [DEPTH-1:0]             fetch_by_age
);
  localparam int AW = $clog2(DEPTH);
  localparam int FW = $clog2(DEPTH+1);

  trace_ent_t      mem [DEPTH];
  logic [AW-1:0]   wr_ptr;

  // age 0 is the slot just behind the write pointer; wraps modulo DEPTH
  function automatic logic [AW-1:0] slot_of(input logic [AW-1:0] ptr, input logic [AW-1:0] age);
    logic [AW:0] s;
    s = {1'b0, ptr} + (AW+1)'(DEPTH-1) - {1'b0, age};
    if (s >= (AW+1)'(DEPTH)) s = s - (AW+1)'(DEPTH);
    return s[AW-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      fill   <= '0;
    end else if (wr_en) begin
      wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (fill != FW'(DEPTH)) fill <= fill + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_ent;
  end

  assign rd_ent = mem[slot_of(wr_ptr, rd_age)];

  always_comb begin
    for (int a = 0; a < DEPTH; a++) begin
      fetch_by_age[a] = (a < int'(fill)) && mem[slot_of(wr_ptr, AW'(a))].fetch;
    end
  end

  assert_fill_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fill <= FW'(DEPTH)) && (wr_ptr < AW'(DEPTH)));
  assert_fill_grows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && fill < FW'(DEPTH)) |=> fill == $past(fill) + 1'b1);
endmodule

// File: rtl/trace_seek.sv
module trace_seek #(
  parameter int DEPTH = 252
) (
  input  logic [DEPTH-1:0]         fetch_by_age,
  input  logic [$clog2(DEPTH)-1:0] cur_age,
  output logic                     older_hit,
  output logic [$clog2(DEPTH)-1:0] older_age,
  output logic                     newer_hit,
  output logic [$clog2(DEPTH)-1:0] newer_age
);
  localparam int AW = $clog2(DEPTH);

  // older: smallest age above cursor carrying a fetch
  always_comb begin
    older_hit = 1'b0;
    older_age = cur_age;
    for (int a = DEPTH-1; a >= 0; a--) begin
      if (a > int'(cur_age) && fetch_by_age[a]) begin
        older_hit = 1'b1;
        older_age = AW'(a);
      end
    end
  end

  // newer: largest age below cursor carrying a fetch
  always_comb begin
    newer_hit = 1'b0;
    newer_age = cur_age;
    for (int a = 0; a < DEPTH; a++) begin
      if (a < int'(cur_age) && fetch_by_age[a]) begin
        newer_hit = 1'b1;
        newer_age = AW'(a);
      end
    end
  end
endmodule

// File: rtl/trace_cursor.sv
module trace_cursor #(
  parameter int DEPTH = 252
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         running,
  input  logic                         stop_bkpt,
  input  logic                         rec,
  input  logic                         rec_fetch,
  input  logic                         rec_bkpt,
  input  logic [$clog2(DEPTH+1)-1:0]   fill,
  input  logic                         inc,
  input  logic                         dec,
  input  logic                         skip,
  input  logic                         older_hit,
  input  logic [$clog2(DEPTH)-1:0]     older_age,
  input  logic                         newer_hit,
  input  logic [$clog2(DEPTH)-1:0]     newer_age,
  output logic [$clog2(DEPTH)-1:0]     cur_age
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW-1:0] OLDEST = AW'(DEPTH-1);

  logic          run_q;
  logic          f_ok, b_ok, nf_ok, nb_ok;
  logic [AW-1:0] f_age, b_age, nf_age, nb_age, nxt;
  logic          pause_entry;

  assign pause_entry = run_q && !running;

  always_comb begin
    nf_ok = f_ok; nf_age = f_age;
    nb_ok = b_ok; nb_age = b_age;
    if (rec) begin
      if (rec_fetch) begin
        nf_ok = 1'b1; nf_age = '0;
      end else if (f_ok && f_age != OLDEST) begin
        nf_age = f_age + 1'b1;
      end else begin
        nf_ok = 1'b0;
      end
      if (rec_bkpt) begin
        nb_ok = 1'b1; nb_age = '0;
      end else if (b_ok && b_age != OLDEST) begin
        nb_age = b_age + 1'b1;
      end else begin
        nb_ok = 1'b0;
      end
    end
  end

  always_comb begin
    nxt = cur_age;
    if (pause_entry) begin
      if (stop_bkpt && nb_ok) nxt = nb_age;
      else                    nxt = nf_ok ? nf_age : '0;
    end else if (!running && rec) begin
      nxt = nf_ok ? nf_age : '0;
    end else if (!running && (inc ^ dec)) begin
      if (inc) begin
        if (skip) begin
          if (newer_hit) nxt = newer_age;
        end else if (cur_age != '0) begin
          nxt = cur_age - 1'b1;
        end
      end else begin
        if (skip) begin
          if (older_hit) nxt = older_age;
        end else if (int'(cur_age) + 1 < int'(fill)) begin
          nxt = cur_age + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      f_ok    <= 1'b0;
      b_ok    <= 1'b0;
      f_age   <= '0;
      b_age   <= '0;
      cur_age <= '0;
    end else begin
      run_q   <= running;
      f_ok    <= nf_ok;
      b_ok    <= nb_ok;
      f_age   <= nf_age;
      b_age   <= nb_age;
      cur_age <= nxt;
    end
  end

  assert_run_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> $stable(cur_age));
  assert_cursor_inside_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fill != '0) |-> (int'(cur_age) < int'(fill)));
  assert_inc_floor_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !run_q && !rec && inc && !dec && !skip && cur_age == '0) |=> cur_age == '0);
endmodule

// File: rtl/trace_ring.sv
module trace_ring
  import trace_pkg::*;
#(
  parameter int DEPTH = 252
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cap_valid,
  output logic                       cap_ready,
  input  logic [ADDR_W-1:0]          cap_addr,
  input  logic [DATA_W-1:0]          cap_data,
  input  logic                       cap_fetch,
  input  logic                       cap_rd,
  input  logic                       cap_wr,
  input  logic                       cap_bkpt,
  input  logic                       inhibit,
  input  logic                       running,
  input  logic                       stop_bkpt,
  input  logic                       br_inc,
  input  logic                       br_dec,
  input  logic                       br_skip,
  output logic [ADDR_W-1:0]          view_addr,
  output logic [DATA_W-1:0]          view_data,
  output logic                       view_fetch,
  output logic                       view_rd,
  output logic                       view_wr,
  output logic [$clog2(DEPTH)-1:0]   view_age,
  output logic                       view_valid
);
  localparam int AW = $clog2(DEPTH);
  localparam int FW = $clog2(DEPTH+1);

  logic              rdy_q, rec;
  trace_ent_t        in_ent, out_ent;
  logic [FW-1:0]     fill;
  logic [DEPTH-1:0]  fetch_by_age;
  logic              older_hit, newer_hit;
  logic [AW-1:0]     older_age, newer_age, cur_age;

  always_ff @(posedge clk) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= 1'b1;
  end

  assign cap_ready = rdy_q;
  assign rec       = cap_valid && rdy_q && !(running && inhibit);
  assign in_ent    = '{addr: cap_addr, data: cap_data, fetch: cap_fetch, rd: cap_rd, wr: cap_wr};

  trace_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(rec), .wr_ent(in_ent),
    .rd_age(cur_age), .rd_ent(out_ent), .fill(fill), .fetch_by_age(fetch_by_age)
  );

  trace_seek #(.DEPTH(DEPTH)) u_seek (
    .fetch_by_age(fetch_by_age), .cur_age(cur_age),
    .older_hit(older_hit), .older_age(older_age),
    .newer_hit(newer_hit), .newer_age(newer_age)
  );

  trace_cursor #(.DEPTH(DEPTH)) u_cursor (
    .clk(clk), .rst_n(rst_n), .running(running), .stop_bkpt(stop_bkpt),
    .rec(rec), .rec_fetch(cap_fetch), .rec_bkpt(cap_bkpt), .fill(fill),
    .inc(br_inc), .dec(br_dec), .skip(br_skip),
    .older_hit(older_hit), .older_age(older_age),
    .newer_hit(newer_hit), .newer_age(newer_age), .cur_age(cur_age)
  );

  assign view_addr  = out_ent.addr;
  assign view_data  = out_ent.data;
  assign view_fetch = out_ent.fetch;
  assign view_rd    = out_ent.rd;
  assign view_wr    = out_ent.wr;
  assign view_age   = cur_age;
  assign view_valid = (fill != '0);

  assert_inhibit_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (running && inhibit) |=> $stable(fill));
  assert_ready_after_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> cap_ready);
  assert_skip_lands_fetch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !rec && br_skip && (br_inc ^ br_dec) && $past(!running) && view_fetch)
      |=> view_fetch);
endmodule

// File: tb/trace_ring_test.sv
`timescale 1ns/100ps
module trace_ring_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cap_valid = 0, cap_fetch = 0, cap_rd = 0, cap_wr = 0, cap_bkpt = 0;
  logic [15:0] cap_addr = '0;
  logic [7:0]  cap_data = '0;
  logic inhibit = 0, running = 0, stop_bkpt = 0, br_inc = 0, br_dec = 0, br_skip = 0;
  logic cap_ready, view_fetch, view_rd, view_wr, view_valid;
  logic [15:0] view_addr;
  logic [7:0]  view_data, view_age;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [27:0] hist [$];   // {bkpt, fetch, rd, wr, data, addr}
  int  m_cur = 0;
  bit  m_prev_run = 0;

  always #2.5 clk = ~clk;

  trace_ring uut (
    .clk(clk), .rst_n(rst_n), .cap_valid(cap_valid), .cap_ready(cap_ready),
    .cap_addr(cap_addr), .cap_data(cap_data), .cap_fetch(cap_fetch), .cap_rd(cap_rd),
    .cap_wr(cap_wr), .cap_bkpt(cap_bkpt), .inhibit(inhibit), .running(running),
    .stop_bkpt(stop_bkpt), .br_inc(br_inc), .br_dec(br_dec), .br_skip(br_skip),
    .view_addr(view_addr), .view_data(view_data), .view_fetch(view_fetch),
    .view_rd(view_rd), .view_wr(view_wr), .view_age(view_age), .view_valid(view_valid)
  );

  function automatic logic [27:0] at_age(int a);
    return hist[hist.size() - 1 - a];
  endfunction

  function automatic int newest_with(int bitpos);
    for (int a = 0; a < hist.size(); a++)
      if (at_age(a)[bitpos]) return a;
    return -1;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_view(string tag);
    logic [27:0] e;
    check({tag, " cursor"}, 64'(view_age), 64'(m_cur));
    check({tag, " valid"}, 64'(view_valid), 64'(hist.size() > 0));
    if (hist.size() > 0) begin
      e = at_age(m_cur);
      check({tag, " R11 view"}, 64'({view_fetch, view_rd, view_wr, view_data, view_addr}),
            64'(e[26:0]));
    end
  endtask

  task automatic cyc(string tag, bit v, logic [15:0] a, logic [7:0] d, bit f, bit r, bit w,
                     bit b, bit run, bit inh, bit sb, bit bi, bit bd, bit bs);
    bit rec, pe;
    int n, t;
    @(negedge clk);
    cap_valid = v; cap_addr = a; cap_data = d; cap_fetch = f; cap_rd = r; cap_wr = w;
    cap_bkpt = b; running = run; inhibit = inh; stop_bkpt = sb;
    br_inc = bi; br_dec = bd; br_skip = bs;
    rec = v && !(run && inh);
    pe  = m_prev_run && !run;
    if (rec) begin
      hist.push_back({b, f, r, w, d, a});
      if (hist.size() > 252) void'(hist.pop_front());
    end
    n = hist.size();
    if (pe) begin
      t = newest_with(27);
      if (sb && t >= 0) m_cur = t;
      else begin t = newest_with(26); m_cur = (t >= 0) ? t : 0; end
    end else if (!run && rec) begin
      t = newest_with(26); m_cur = (t >= 0) ? t : 0;
    end else if (!run && (bi ^ bd)) begin
      if (bi) begin
        if (bs) begin
          for (int k = m_cur - 1; k >= 0; k--) if (at_age(k)[26]) begin m_cur = k; break; end
        end else if (m_cur > 0) m_cur--;
      end else begin
        if (bs) begin
          for (int k = m_cur + 1; k < n; k++) if (at_age(k)[26]) begin m_cur = k; break; end
        end else if (m_cur + 1 < n) m_cur++;
      end
    end
    m_prev_run = run;
    @(posedge clk);
    #1;
    check_view(tag);
  endtask

  task automatic rnd_capture(string tag, bit run, int pinh, int pbk, bit allow_fetch);
    cyc(tag, 1'b1, 16'($urandom), 8'($urandom), allow_fetch && ($urandom_range(0, 2) == 0),
        1'($urandom), 1'($urandom), $urandom_range(0, 99) < pbk, run,
        $urandom_range(0, 99) < pinh, 1'b0, 1'($urandom), 1'($urandom), 1'b0);
  endtask

  task automatic idle(string tag, bit run, bit sb);
    cyc(tag, 0, '0, '0, 0, 0, 0, 0, run, 0, sb, 0, 0, 0);
  endtask

  task automatic browse(string tag, bit bi, bit bd, bit bs);
    cyc(tag, 0, '0, '0, 0, 0, 0, 0, 0, 0, 0, bi, bd, bs);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1;
    check("R1 ready in reset", 64'(cap_ready), 64'd0);
    check("R1 valid in reset", 64'(view_valid), 64'd0);
    check("R1 age in reset", 64'(view_age), 64'd0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R2 ready after reset", 64'(cap_ready), 64'd1);

    // R7: empty history, browse does nothing
    browse("R7 empty dec", 0, 1, 0);
    browse("R7 empty inc", 1, 0, 0);

    // R4/R10/R12: paused single-step captures with a browse collision
    cyc("R4 step fetch", 1, 16'h4000, 8'h22, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc("R4 step rd", 1, 16'h4001, 8'h55, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc("R12 step with dec", 1, 16'h7055, 8'h34, 0, 0, 1, 0, 0, 1, 0, 0, 1, 0);
    browse("R7 inc to newer", 1, 0, 0);
    browse("R7 dec", 0, 1, 0);
    browse("R7 dec to oldest", 0, 1, 0);
    browse("R7 dec clamp", 0, 1, 0);
    browse("R7 both held", 1, 1, 0);

    // R3/R5: long run with inhibit, then manual stop (R10)
    for (int i = 0; i < 320; i++) rnd_capture("R5 run capture", 1, 20, 0, 1);
    idle("R10 manual stop", 0, 0);
    for (int i = 0; i < 260; i++) browse("R3 dec to limit", 0, 1, 0);
    check("R3 oldest age", 64'(view_age), 64'd251);
    for (int i = 0; i < 300; i++) browse("R7 inc to newest", 1, 0, 0);

    // R8: random browse with fetch skip
    for (int i = 0; i < 600; i++)
      browse("R8 random browse", 1'($urandom), 1'($urandom), $urandom_range(0, 1) == 0);

    // R6: browse while running is ignored
    idle("R6 resume", 1, 0);
    for (int i = 0; i < 20; i++) rnd_capture("R6 run browse", 1, 0, 0, 1);

    // R9: breakpoint stop
    for (int i = 0; i < 40; i++) rnd_capture("R9 run", 1, 0, 8, 1);
    cyc("R9 bkpt cycle", 1, 16'hEB22, 8'h5A, 0, 1, 0, 1, 1, 0, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) rnd_capture("R9 tail", 1, 0, 0, 1);
    idle("R9 bkpt stop", 0, 1);
    check("R9 bkpt addr", 64'(view_addr), 64'hEB22);

    // R5: inhibit while paused has no effect
    cyc("R5 paused inhibit", 1, 16'h1313, 8'hA0, 1, 0, 1, 0, 0, 1, 0, 0, 0, 0);
    check("R5 paused recorded", 64'(view_addr), 64'h1313);

    // R8/R10: flush all fetch entries, then skip has nowhere to go
    idle("R10 resume", 1, 0);
    for (int i = 0; i < 260; i++) rnd_capture("R10 no fetch run", 1, 0, 0, 0);
    idle("R10 stop without fetch", 0, 1);
    check("R10 no fetch age", 64'(view_age), 64'd0);
    for (int i = 0; i < 5; i++) browse("R8 skip none dec", 0, 1, 1);
    browse("R7 dec step", 0, 1, 0);
    browse("R8 skip none inc", 1, 0, 1);

    // mixed run/step random phases
    for (int p = 0; p < 6; p++) begin
      idle("R4 mixed resume", 1, 0);
      for (int i = 0; i < 60; i++) rnd_capture("R4 mixed run", 1, 10, 3, 1);
      idle("R9 mixed stop", 0, 1'($urandom));
      for (int i = 0; i < 30; i++) begin
        if ($urandom_range(0, 4) == 0) rnd_capture("R4 mixed step", 0, 50, 3, 1);
        else browse("R8 mixed browse", 1'($urandom), 1'($urandom), 1'($urandom));
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule